// File: doc/BRIEF.md
# Asynchronous Parallel Bus Slave with Busy Throttle

This block sits behind an 8/16-bit asynchronous parallel host bus with active-low chip select, read strobe, write strobe and high-byte enable. All of these inputs, the address and the write data are brought into the system clock through multi-flop synchronizers. Strobe edges are then detected in the clock domain. Writes are posted: the address, data and width are taken at the moment the write strobe is released. The value is then committed to a small internal register array that exists so the path can be tested.

After a write is posted, the block raises a busy output for an internal write time. That time is set in nanoseconds, with one value for byte writes and one for word writes, and is converted to clock cycles. Reads return a whole word once busy drops. A read that comes directly after a byte write to the same location gets a short extra delay. A read that starts while a write is still in progress waits for that write to finish. A host that starts a new write while busy is high keeps its strobe low until busy clears. Its external write time therefore grows by whatever internal write time is left.

Top module: `mcu_bus_slave`

## Requirements
- R1: After reset, busy is low, rdata is zero and every word of the storage reads back as zero.
- R2: A write is accepted on the release of the write strobe, using the address, data and high-byte enable held at that time. Busy goes high at the third rising clock edge after wr_n rises, and not earlier.
- R3: After an accepted byte write, busy stays high for exactly ceil(T_WR8_NS / CLK_PERIOD_NS) cycles (18 at the default values).
- R4: After an accepted word write, busy stays high for exactly ceil(T_WR16_NS / CLK_PERIOD_NS) cycles (26 at the default values).
- R5: An access is a word access when bhe_n is 0 and addr[0] is 0. Otherwise it is a byte access. A byte access at an even address uses the low lane, wdata[7:0] into bits 7:0. A byte access at an odd address uses the high lane, wdata[15:8] into bits 15:8. A byte write leaves the other lane of the word unchanged.
- R6: A read returns the full 16-bit word at addr[AW-1:1] on rdata, valid once busy is low. When no write is running and there is no collision, busy is high for exactly one cycle of the read.
- R7: A collision is a read that directly follows a byte write with no access in between, where either the read is a byte read at the same byte address or it is a word read of the same word. A collision adds ceil(T_COLL_NS / CLK_PERIOD_NS) cycles (2 at default), so busy is high for that count plus one. Reads after word writes, and reads to other locations, get no extra delay.
- R8: A read that starts while an internal write is running is held until that write completes, with busy kept high throughout, and returns the newly written data.
- R9: A write strobe released while an internal write is still running is discarded. Storage is unchanged and the running write time is not restarted.
- R10: Strobes are ignored while cs_n is high. An access counts as ended when the strobe is seen released after a sample in which both chip select and the strobe were active, so chip select may rise together with the strobe.
- R11: A host that asserts a new write while busy is high and releases it only after busy falls gets that write committed, with a fresh internal write time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bhe_n | input | 1 | High-byte enable, active low |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data from the host |
| rdata | output | DW | Read data word, valid when busy is low after a read |
| busy | output | 1 | High while an internal write or a delayed read is in progress |

## Verification
The embedded properties assume a well-behaved host in several ways. Address, data and the high-byte enable stay steady for at least two clock cycles after a write strobe is released. Each strobe is held for at least two cycles. A read start and a write end are never detected in the same cycle. The host does not start a second read before the first has completed. The stimulus keeps every access within these limits, and it changes address and data only on a falling clock edge well after the capture point. The only deliberate exceptions are the overlapping-write cases of R9 and R11, which are timed so that the second strobe release falls inside the running internal write. A behavioural model in the bench predicts busy and rdata on every cycle. It is backed by directed checks of the busy rise delay, the busy lengths for byte and word writes, collisions and read-back data.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   // Round a duration in ns up to whole clock cycles.
   function automatic int ns_to_cyc(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   // Byte enables for a two-lane word
   typedef enum logic [1:0] {
      BE_NONE = 2'b00,
      BE_LO   = 2'b01,
      BE_HI   = 2'b10,
      BE_WORD = 2'b11
   } lane_be_e;

endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbs_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("mbs_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
   parameter int WAW   = 5,
   parameter int DW    = 16,
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [WAW-1:0]   waddr_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [LANES-1:0] wbe_i,
   input  logic [WAW-1:0]   raddr_i,
   output logic [DW-1:0]    rdata_o
);

   localparam int LW    = DW / LANES;
   localparam int DEPTH = 1 << WAW;

   generate
      if (DW % LANES != 0) begin : g_bad_lanes
         $error("mbs_regfile: DW must split evenly into lanes");
      end

      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LW-1:0] mem [DEPTH];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we_i && wbe_i[l]) begin
               mem[waddr_i] <= wdata_i[l*LW +: LW];
            end
         end

         assign rdata_o[l*LW +: LW] = mem[raddr_i];
      end
   endgenerate

endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
   import mbs_pkg::*;
#(
   parameter int AW       = 6,
   parameter int DW       = 16,
   parameter int W8_CYC   = 18,
   parameter int W16_CYC  = 26,
   parameter int COLL_CYC = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_i,
   input  logic           rd_i,
   input  logic           wr_i,
   input  logic           hi_en_i,
   input  logic [AW-1:0]  addr_i,
   input  logic [DW-1:0]  wdata_i,
   output logic           mem_we_o,
   output logic [AW-2:0]  mem_waddr_o,
   output logic [DW-1:0]  mem_wdata_o,
   output logic [1:0]     mem_wbe_o,
   output logic [AW-2:0]  mem_raddr_o,
   input  logic [DW-1:0]  mem_rdata_i,
   output logic [DW-1:0]  rdata_o,
   output logic           busy_o
);

   localparam int TW  = $clog2(max3(W8_CYC, W16_CYC, COLL_CYC) + 1);
   localparam int WAW = AW - 1;

   logic          cs_q, rd_q, wr_q;
   logic          wr_end, rd_start, word_acc, accept, rd_done;
   logic [TW-1:0] wr_tmr, coll_tmr;
   logic          rd_pend;
   logic [WAW-1:0] rd_word_q;
   logic [DW-1:0] rdata_q;
   lane_be_e      be;

   // Previous synchronized strobe levels for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b0;
         rd_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         cs_q <= cs_i;
         rd_q <= rd_i;
         wr_q <= wr_i;
      end
   end

   assign wr_end   = wr_q & ~wr_i & cs_q;
   assign rd_start = rd_i & ~rd_q & cs_i;
   assign word_acc = hi_en_i & ~addr_i[0];
   assign accept   = wr_end & (wr_tmr == '0);
   assign rd_done  = rd_pend & (wr_tmr == '0) & (coll_tmr == '0);

   always_comb begin
      if (word_acc)       be = BE_WORD;
      else if (addr_i[0]) be = BE_HI;
      else                be = BE_LO;
   end

   assign mem_we_o    = accept;
   assign mem_waddr_o = addr_i[AW-1:1];
   assign mem_wdata_o = wdata_i;
   assign mem_wbe_o   = be;
   assign mem_raddr_o = rd_word_q;

   // Internal write timer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_tmr <= '0;
      end else if (accept) begin
         wr_tmr <= word_acc ? TW'(W16_CYC) : TW'(W8_CYC);
      end else if (wr_tmr != '0) begin
         wr_tmr <= wr_tmr - 1'b1;
      end
   end

   // Read tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend   <= 1'b0;
         rd_word_q <= '0;
         rdata_q   <= '0;
      end else if (rd_start) begin
         rd_pend   <= 1'b1;
         rd_word_q <= addr_i[AW-1:1];
      end else if (rd_done) begin
         rd_pend <= 1'b0;
         rdata_q <= mem_rdata_i;
      end
   end

   // Same-location collision delay, present only when configured
   generate
      if (COLL_CYC > 0) begin : g_coll
         logic          l8_vld;
         logic [AW-1:0] l8_addr;
         logic          hit;

         assign hit = l8_vld & (word_acc ? (l8_addr[AW-1:1] == addr_i[AW-1:1])
                                         : (l8_addr == addr_i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               l8_vld  <= 1'b0;
               l8_addr <= '0;
            end else if (accept) begin
               l8_vld  <= ~word_acc;
               l8_addr <= addr_i;
            end else if (rd_start) begin
               l8_vld <= 1'b0;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               coll_tmr <= '0;
            end else if (rd_start) begin
               coll_tmr <= hit ? TW'(COLL_CYC) : '0;
            end else if (coll_tmr != '0) begin
               coll_tmr <= coll_tmr - 1'b1;
            end
         end
      end else begin : g_no_coll
         assign coll_tmr = '0;
      end
   endgenerate

   assign rdata_o = rdata_q;
   assign busy_o  = (wr_tmr != '0) | (coll_tmr != '0) | rd_pend;

   // Accepted write must show busy on the next cycle
   p_busy_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o);

   // Running write timer counts down by one per cycle
   p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tmr != '0) |=> (wr_tmr == $past(wr_tmr) - 1'b1));

   // A strobe release during a running write does not restart it
   p_drop_late_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_end && wr_tmr != '0) |=> (wr_tmr == $past(wr_tmr) - 1'b1));

   // Collision delay only exists inside a pending read
   p_coll_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_tmr != '0) |-> rd_pend);

   // A read stays pending while a write is running
   p_read_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pend && wr_tmr != '0) |=> rd_pend);

   // Read data moves only when a read completes
   p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_pend |=> $stable(rdata_q));

endmodule

// File: rtl/mcu_bus_slave.sv
module mcu_bus_slave
   import mbs_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_WR8_NS      = 180,
   parameter int T_WR16_NS     = 260,
   parameter int T_COLL_NS     = 20,
   parameter int AW            = 6,
   parameter int DW            = 16,
   parameter int SYNC_STAGES   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          bhe_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          busy
);

   localparam int W8_CYC   = ns_to_cyc(T_WR8_NS, CLK_PERIOD_NS);
   localparam int W16_CYC  = ns_to_cyc(T_WR16_NS, CLK_PERIOD_NS);
   localparam int COLL_CYC = ns_to_cyc(T_COLL_NS, CLK_PERIOD_NS);
   localparam int SW       = 4 + AW + DW;
   localparam int WAW      = AW - 1;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("mcu_bus_slave: AW must be at least 2");
      end
      if (DW != 16) begin : g_bad_dw
         $error("mcu_bus_slave: DW must be 16 (two byte lanes)");
      end
      if (CLK_PERIOD_NS < 1 || W8_CYC < 1 || W16_CYC < 1) begin : g_bad_time
         $error("mcu_bus_slave: timing parameters must give positive cycle counts");
      end
   endgenerate

   logic [SW-1:0] raw_bus, syn_bus;
   logic          cs_s, rd_s, wr_s, hi_s;
   logic [AW-1:0] addr_s;
   logic [DW-1:0] wdata_s;

   assign raw_bus = {~cs_n, ~rd_n, ~wr_n, ~bhe_n, addr, wdata};

   mbs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_bus),
      .q_o   (syn_bus)
   );

   assign {cs_s, rd_s, wr_s, hi_s, addr_s, wdata_s} = syn_bus;

   logic           mem_we;
   logic [WAW-1:0] mem_waddr, mem_raddr;
   logic [DW-1:0]  mem_wdata, mem_rdata;
   logic [1:0]     mem_wbe;

   mbs_ctrl #(
      .AW       (AW),
      .DW       (DW),
      .W8_CYC   (W8_CYC),
      .W16_CYC  (W16_CYC),
      .COLL_CYC (COLL_CYC)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_i        (cs_s),
      .rd_i        (rd_s),
      .wr_i        (wr_s),
      .hi_en_i     (hi_s),
      .addr_i      (addr_s),
      .wdata_i     (wdata_s),
      .mem_we_o    (mem_we),
      .mem_waddr_o (mem_waddr),
      .mem_wdata_o (mem_wdata),
      .mem_wbe_o   (mem_wbe),
      .mem_raddr_o (mem_raddr),
      .mem_rdata_i (mem_rdata),
      .rdata_o     (rdata),
      .busy_o      (busy)
   );

   mbs_regfile #(.WAW(WAW), .DW(DW), .LANES(2)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .waddr_i (mem_waddr),
      .wdata_i (mem_wdata),
      .wbe_i   (mem_wbe),
      .raddr_i (mem_raddr),
      .rdata_o (mem_rdata)
   );

   // Storage is written only with at least one lane enabled
   p_lane_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wbe != 2'b00));

endmodule

// File: tb/sim_mcu_bus_slave.sv
module sim_mcu_bus_slave;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 6;
   localparam int W8   = (180 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int W16  = (260 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int COLL = (20 + CLK_PERIOD - 1) / CLK_PERIOD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, bhe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0]   wdata = '0;
   logic [15:0]   rdata;
   logic          busy;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcu_bus_slave #(.CLK_PERIOD_NS(CLK_PERIOD), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .bhe_n(bhe_n), .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          p1c, p1r, p1w, p1b, p2c, p2r, p2w, p2b, p3c, p3r, p3w;
   int          p1a, p2a, p1d, p2d;
   int          m_wr, m_co, m_rw;
   bit          m_rp, l8v;
   int          l8a;
   logic [15:0] m_rd;
   logic [15:0] m_mem [32];

   always @(posedge clk) begin
      if (!rst_n) begin
         {p1c,p1r,p1w,p1b,p2c,p2r,p2w,p2b,p3c,p3r,p3w} = '0;
         p1a = 0; p2a = 0; p1d = 0; p2d = 0;
         m_wr = 0; m_co = 0; m_rw = 0; m_rp = 0; l8v = 0; l8a = 0; m_rd = '0;
         for (int i = 0; i < 32; i++) m_mem[i] = '0;
      end else begin
         bit wend, rstart, isword, hit, old_rp;
         int old_wr, old_co;
         wend   = p3w && !p2w && p3c;
         rstart = p2r && !p3r && p2c;
         isword = p2b && (p2a % 2 == 0);
         old_wr = m_wr; old_co = m_co; old_rp = m_rp;
         if (wend && old_wr == 0) begin
            if (isword) m_mem[p2a/2] = p2d[15:0];
            else if (p2a % 2 == 1) m_mem[p2a/2][15:8] = p2d[15:8];
            else m_mem[p2a/2][7:0] = p2d[7:0];
            m_wr = isword ? W16 : W8;
            l8v = !isword; l8a = p2a;
         end else if (old_wr > 0) m_wr = old_wr - 1;
         if (rstart) begin
            hit = l8v && (isword ? (l8a/2 == p2a/2) : (l8a == p2a));
            m_rp = 1; m_rw = p2a/2; m_co = hit ? COLL : 0; l8v = 0;
         end else begin
            if (old_co > 0) m_co = old_co - 1;
            if (old_rp && old_wr == 0 && old_co == 0) begin
               m_rd = m_mem[m_rw]; m_rp = 0;
            end
         end
         p3c = p2c; p3r = p2r; p3w = p2w;
         p2c = p1c; p2r = p1r; p2w = p1w; p2b = p1b; p2a = p1a; p2d = p1d;
         p1c = !cs_n; p1r = !rd_n; p1w = !wr_n; p1b = !bhe_n; p1a = int'(addr); p1d = int'(wdata);
      end
   end

   // Compare against the model on every clock, away from the edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit mb;
         mb = (m_wr > 0) || (m_co > 0) || m_rp;
         chk(busy == mb, "R2 model busy", int'(busy), int'(mb));
         chk(rdata == m_rd, "R6 model rdata", int'(rdata), int'(m_rd));
      end
   end

   // ---------------- host tasks ----------------
   task automatic wr_begin(input int a, input logic [15:0] d, input bit bn);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; bhe_n = bn; addr = AW'(a); wdata = d;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr_release();
      wr_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic meas_busy(output int rise, output int len);
      rise = -1;
      for (int n = 1; n <= 20; n++) begin
         @(negedge clk);
         if (busy) begin rise = n; break; end
      end
      len = 0;
      while (busy && len < 1000) begin
         len++;
         @(negedge clk);
      end
   endtask

   task automatic rd_access(input int a, input bit bn, output logic [15:0] d, output int blen);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; bhe_n = bn; addr = AW'(a);
      blen = 0;
      for (int n = 1; n <= 300; n++) begin
         @(negedge clk);
         if (busy) blen++;
         else if (n >= 4) break;
      end
      d = rdata;
      @(negedge clk);
      rd_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic wait_idle();
      int g;
      g = 0;
      while (busy && g < 500) begin @(negedge clk); g++; end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [15:0] d;
      int rise, len, bl, ext;
      bit quiet;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      chk(rdata == 16'h0, "R1 rdata after reset", int'(rdata), 0);

      rd_access(4, 1'b0, d, bl);
      chk(d == 16'h0, "R1 storage cleared", int'(d), 0);
      chk(bl == 1, "R6 plain read busy length", bl, 1);

      // Word write
      wr_begin(4, 16'hA5C3, 1'b0); wr_release();
      meas_busy(rise, len);
      chk(rise == 3, "R2 busy rise delay", rise, 3);
      chk(len == W16, "R4 word write busy length", len, W16);
      rd_access(4, 1'b0, d, bl);
      chk(d == 16'hA5C3, "R6 word read-back", int'(d), 'hA5C3);
      chk(bl == 1, "R7 no collision after word write", bl, 1);

      // Byte write, high lane
      wr_begin(5, 16'h7E11, 1'b0); wr_release();
      meas_busy(rise, len);
      chk(len == W8, "R3 byte write busy length", len, W8);
      rd_access(5, 1'b0, d, bl);
      chk(bl == COLL + 1, "R7 same-byte collision", bl, COLL + 1);
      chk(d == 16'h7EC3, "R5 high lane merge", int'(d), 'h7EC3);

      // Byte write, low lane, then word read of same word
      wr_begin(8, 16'hEE3C, 1'b1); wr_release();
      meas_busy(rise, len);
      chk(len == W8, "R3 low-lane byte busy length", len, W8);
      rd_access(8, 1'b0, d, bl);
      chk(bl == COLL + 1, "R7 word read after byte write collision", bl, COLL + 1);
      chk(d == 16'h003C, "R5 low lane write", int'(d), 'h003C);

      // Byte write then read elsewhere
      wr_begin(10, 16'h0055, 1'b1); wr_release();
      meas_busy(rise, len);
      rd_access(12, 1'b1, d, bl);
      chk(bl == 1, "R7 other address no collision", bl, 1);

      // Write strobe with chip select high
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b0; bhe_n = 1'b0; addr = AW'(4); wdata = 16'hFFFF;
      repeat (2) @(negedge clk);
      wr_n = 1'b1;
      quiet = 1'b1;
      repeat (8) begin @(negedge clk); if (busy) quiet = 1'b0; end
      chk(quiet, "R10 no busy without chip select", int'(quiet), 1);
      rd_access(4, 1'b0, d, bl);
      chk(d == 16'h7EC3, "R10 storage untouched", int'(d), 'h7EC3);

      // Second release during a running write is dropped
      wr_begin(20, 16'h1111, 1'b0); wr_release();
      repeat (3) @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; addr = AW'(22); wdata = 16'h2222;
      repeat (2) @(negedge clk);
      wr_release();
      wait_idle();
      rd_access(22, 1'b0, d, bl);
      chk(d == 16'h0000, "R9 late write discarded", int'(d), 0);
      rd_access(20, 1'b0, d, bl);
      chk(d == 16'h1111, "R9 first write kept", int'(d), 'h1111);

      // Host holds a new write until busy clears
      wr_begin(24, 16'hBEEF, 1'b0); wr_release();
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; addr = AW'(26); wdata = 16'hCAFE;
      ext = 0;
      while (!busy && ext < 20) begin @(negedge clk); ext++; end
      while (busy && ext < 500) begin @(negedge clk); ext++; end
      chk(ext >= W16, "R11 external write stretched", ext, W16);
      wr_release();
      meas_busy(rise, len);
      chk(len == W16, "R11 fresh internal write time", len, W16);
      rd_access(26, 1'b0, d, bl);
      chk(d == 16'hCAFE, "R11 held write committed", int'(d), 'hCAFE);
      rd_access(24, 1'b0, d, bl);
      chk(d == 16'hBEEF, "R11 first write committed", int'(d), 'hBEEF);

      // Read right after write release
      wr_begin(40, 16'h0F0F, 1'b0); wr_release();
      rd_access(40, 1'b0, d, bl);
      chk(d == 16'h0F0F, "R8 read waits for write", int'(d), 'h0F0F);
      chk(bl == W16 + 1, "R8 busy spans write and read", bl, W16 + 1);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule